// File: doc/BRIEF.md
# Scaled Radix-2 Frequency-Decimation Butterfly

This block is the arithmetic core of one stage of a pipelined radix-2 decimation-in-frequency transform. It is purely combinational. It takes two complex operands, A and B, and one complex twiddle factor, W. It returns the halved sum (A+B)/2 and the halved, rotated difference ((A−B)·W)/2.

Every part of every operand and result is an 8-bit signed two's complement value. The twiddle is read as a fraction with 7 fractional bits, so 127 stands for just under one.

The halving gives each stage a gain of one half, so a chain of six such stages scales the whole transform by 1/64 and the values can never grow past the 8-bit range. Each halving adds half an LSB before the arithmetic shift, which rounds exact halves toward positive infinity. The intermediate sums and products are carried in a widened accumulator so that they never wrap. Each result is then clipped to the 8-bit range. Pipeline registers, twiddle generation and the steering of data between stages belong to the surrounding stage logic.

Top module: `bfly_dif_scaled`

## Requirements
- R1: `sum_re` equals floor((a_re + b_re + 1) / 2), taken as integers.
- R2: `sum_im` equals floor((a_im + b_im + 1) / 2), taken as integers.
- R3: With dr = a_re − b_re and di = a_im − b_im, `dif_re` equals floor((dr·w_re − di·w_im + 128) / 256), clipped to the range −128..127.
- R4: `dif_im` equals floor((dr·w_im + di·w_re + 128) / 256), clipped to the range −128..127.
- R5: A result that lies exactly halfway between two integers rounds upward. For example, a sum of 3 gives 2, and a sum of −3 gives −1.
- R6: A rotated difference whose magnitude is too large for 8 bits saturates. It gives 127 when positive and −128 when negative; it never wraps.
- R7: With W = (127, 0) and B = 0, each part of `dif` lies within 1 LSB of half of the matching part of A.
- R8: With W = (0, 0), both parts of `dif` are 0 whatever A and B are.
- R9: The outputs depend only on the present inputs. Any input vector, whatever the vectors applied before it, gives its own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_re | input | 8 | Real part of operand A, signed |
| a_im | input | 8 | Imaginary part of operand A, signed |
| b_re | input | 8 | Real part of operand B, signed |
| b_im | input | 8 | Imaginary part of operand B, signed |
| w_re | input | 8 | Twiddle real part, signed, 7 fractional bits |
| w_im | input | 8 | Twiddle imaginary part, signed, 7 fractional bits |
| sum_re | output | 8 | Real part of (A+B)/2, rounded |
| sum_im | output | 8 | Imaginary part of (A+B)/2, rounded |
| dif_re | output | 8 | Real part of ((A−B)·W)/2, rounded and clipped |
| dif_im | output | 8 | Imaginary part of ((A−B)·W)/2, rounded and clipped |

## Verification
The checker assumes that every input bit is a known 0 or 1, and it evaluates nothing while any input is unknown. The bench meets this by driving fully defined vectors from the first cycle on.

The twiddle checks assume nothing about the twiddle beyond its 8-bit range. The stimulus therefore draws W over all values, including −128, which a real twiddle ROM never emits, so that the saturation corners are reached. The extreme operand pairs are applied as directed cases, because random draws rarely reach them.

// File: rtl/fft_bfly_pkg.sv
package fft_bfly_pkg;
  // Default sample width for real and imaginary parts.
  localparam int unsigned BF_DW    = 8;
  // Fractional bits of the twiddle coefficients.
  localparam int unsigned BF_WFRAC = 7;
  // Lanes handled by the rounding stage: sum re/im, diff re/im.
  localparam int unsigned BF_LANES = 4;
endpackage

// File: rtl/bfly_round_sat.sv
module bfly_round_sat #(
  parameter int unsigned IN_W  = 18,
  parameter int unsigned SHIFT = 1,
  parameter int unsigned OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic signed [IN_W-1:0] HALF = IN_W'(1 << (SHIFT - 1));
  localparam logic signed [IN_W-1:0] MAXV = IN_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [IN_W-1:0] MINV = IN_W'(-(1 << (OUT_W - 1)));

  logic signed [IN_W-1:0] biased;
  logic signed [IN_W-1:0] shifted;

  always_comb begin
    biased  = din + HALF;
    shifted = biased >>> SHIFT;
    if (shifted > MAXV) begin
      dout = MAXV[OUT_W-1:0];
    end else if (shifted < MINV) begin
      dout = MINV[OUT_W-1:0];
    end else begin
      dout = shifted[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
  parameter int unsigned DW    = 8,
  parameter int unsigned ACC_W = 18
) (
  input  logic signed [DW:0]      d_re,
  input  logic signed [DW:0]      d_im,
  input  logic signed [DW-1:0]    w_re,
  input  logic signed [DW-1:0]    w_im,
  output logic signed [ACC_W-1:0] p_re,
  output logic signed [ACC_W-1:0] p_im
);
  logic signed [ACC_W-1:0] dr_x, di_x, wr_x, wi_x;

  always_comb begin
    dr_x = ACC_W'(d_re);
    di_x = ACC_W'(d_im);
    wr_x = ACC_W'(w_re);
    wi_x = ACC_W'(w_im);
    p_re = (dr_x * wr_x) - (di_x * wi_x);
    p_im = (dr_x * wi_x) + (di_x * wr_x);
  end
endmodule

// File: rtl/bfly_dif_scaled.sv
module bfly_dif_scaled
  import fft_bfly_pkg::*;
#(
  parameter int unsigned DW    = BF_DW,
  parameter int unsigned WFRAC = BF_WFRAC
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [DW-1:0] w_re,
  input  logic signed [DW-1:0] w_im,
  output logic signed [DW-1:0] sum_re,
  output logic signed [DW-1:0] sum_im,
  output logic signed [DW-1:0] dif_re,
  output logic signed [DW-1:0] dif_im
);
  // Two products of a (DW+1)-bit difference and a DW-bit twiddle, summed.
  localparam int unsigned ACC_W  = 2 * DW + 2;
  localparam int unsigned SHIFT_S = 1;
  localparam int unsigned SHIFT_D = WFRAC + 1;

  logic signed [DW:0]      d_re, d_im;
  logic signed [ACC_W-1:0] p_re, p_im;
  logic signed [ACC_W-1:0] acc [BF_LANES];
  logic signed [DW-1:0]    res [BF_LANES];

  always_comb begin
    d_re   = (DW+1)'(a_re) - (DW+1)'(b_re);
    d_im   = (DW+1)'(a_im) - (DW+1)'(b_im);
    acc[0] = ACC_W'(a_re) + ACC_W'(b_re);
    acc[1] = ACC_W'(a_im) + ACC_W'(b_im);
    acc[2] = p_re;
    acc[3] = p_im;
  end

  bfly_cmul #(
    .DW   (DW),
    .ACC_W(ACC_W)
  ) i_cmul (
    .d_re(d_re),
    .d_im(d_im),
    .w_re(w_re),
    .w_im(w_im),
    .p_re(p_re),
    .p_im(p_im)
  );

  // Lanes 0..1 halve the sum; lanes 2..3 drop the twiddle fraction and halve.
  for (genvar g = 0; g < BF_LANES; g++) begin : g_lane
    localparam int unsigned SH = (g < 2) ? SHIFT_S : SHIFT_D;
    bfly_round_sat #(
      .IN_W (ACC_W),
      .SHIFT(SH),
      .OUT_W(DW)
    ) i_rnd (
      .din (acc[g]),
      .dout(res[g])
    );
  end

  assign sum_re = res[0];
  assign sum_im = res[1];
  assign dif_re = res[2];
  assign dif_im = res[3];
endmodule

// File: rtl/bfly_dif_scaled_chk.sv
module bfly_dif_scaled_chk #(
  parameter int unsigned DW = 8
) (
  input logic signed [DW-1:0] a_re,
  input logic signed [DW-1:0] a_im,
  input logic signed [DW-1:0] b_re,
  input logic signed [DW-1:0] b_im,
  input logic signed [DW-1:0] w_re,
  input logic signed [DW-1:0] w_im,
  input logic signed [DW-1:0] sum_re,
  input logic signed [DW-1:0] sum_im,
  input logic signed [DW-1:0] dif_re,
  input logic signed [DW-1:0] dif_im
);
  localparam int WONE = (1 << (DW - 1)) - 1;

  int s_re, s_im, e_re, e_im, g_re, g_im;

  always_comb begin
    s_re = int'(a_re) + int'(b_re);
    s_im = int'(a_im) + int'(b_im);
    e_re = 2 * int'(sum_re) - s_re;
    e_im = 2 * int'(sum_im) - s_im;
    g_re = 2 * int'(dif_re) - int'(a_re);
    g_im = 2 * int'(dif_im) - int'(a_im);
    if (!$isunknown({a_re, a_im, b_re, b_im, w_re, w_im})) begin
      // R1
      sum_re_step_chk: assert (e_re == 0 || e_re == 1)
        else $error("sum_re off by more than the rounding step");
      // R2
      sum_im_step_chk: assert (e_im == 0 || e_im == 1)
        else $error("sum_im off by more than the rounding step");
      // R5
      half_up_chk: assert (s_re[0] == 1'b0 || e_re == 1)
        else $error("odd sum not rounded upward");
      // R8
      zero_tw_chk: assert (!(w_re == 0 && w_im == 0) || (dif_re == 0 && dif_im == 0))
        else $error("zero twiddle gave nonzero difference");
      // R7
      unity_tw_chk: assert (!(int'(w_re) == WONE && w_im == 0 && b_re == 0 && b_im == 0)
                            || (g_re >= -2 && g_re <= 2 && g_im >= -2 && g_im <= 2))
        else $error("unity twiddle result not near A/2");
    end
  end
endmodule

bind bfly_dif_scaled bfly_dif_scaled_chk #(.DW(DW)) i_bfly_chk (
  .a_re  (a_re),
  .a_im  (a_im),
  .b_re  (b_re),
  .b_im  (b_im),
  .w_re  (w_re),
  .w_im  (w_im),
  .sum_re(sum_re),
  .sum_im(sum_im),
  .dif_re(dif_re),
  .dif_im(dif_im)
);

// File: tb/test_bfly_dif_scaled.sv
module test_bfly_dif_scaled;
  logic clk;
  logic signed [7:0] a_re, a_im, b_re, b_im, w_re, w_im;
  logic signed [7:0] sum_re, sum_im, dif_re, dif_im;
  int checks;
  int failures;
  int cycles;
  bit done;

  bfly_dif_scaled i_bfly_dif_scaled (
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .w_re(w_re), .w_im(w_im),
    .sum_re(sum_re), .sum_im(sum_im), .dif_re(dif_re), .dif_im(dif_im)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int rnd_sat(int v, int sh);
    int r;
    r = (v + (1 << (sh - 1))) >>> sh;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(int ar, int ai, int br, int bi, int wr, int wi);
    @(negedge clk);
    a_re = 8'(ar); a_im = 8'(ai); b_re = 8'(br);
    b_im = 8'(bi); w_re = 8'(wr); w_im = 8'(wi);
    #1;
  endtask

  task automatic check_all(string tag);
    int ar, ai, br, bi, wr, wi, dr, di;
    ar = int'(a_re); ai = int'(a_im); br = int'(b_re);
    bi = int'(b_im); wr = int'(w_re); wi = int'(w_im);
    dr = ar - br; di = ai - bi;
    check({tag, " R1 sum_re"}, int'(sum_re), rnd_sat(ar + br, 1));
    check({tag, " R2 sum_im"}, int'(sum_im), rnd_sat(ai + bi, 1));
    check({tag, " R3 dif_re"}, int'(dif_re), rnd_sat(dr * wr - di * wi, 8));
    check({tag, " R4 dif_im"}, int'(dif_im), rnd_sat(dr * wi + di * wr, 8));
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int a;
    checks = 0; failures = 0; done = 0;
    void'($urandom(32'd20240611));
    // R9: all-zero vector gives all-zero outputs
    apply(0, 0, 0, 0, 0, 0);
    check("R9 zero sum_re", int'(sum_re), 0);
    check("R9 zero dif_im", int'(dif_im), 0);
    check_all("zero");
    // R5: exact halves round up
    apply(2, -2, 1, -1, 0, 0);
    check("R5 3/2", int'(sum_re), 2);
    check("R5 -3/2", int'(sum_im), -1);
    apply(64, 0, 0, 0, 127, 0);
    check("R5 product half", int'(dif_re), 32);
    // R6: saturation at both ends
    apply(127, 127, -128, -128, 127, -128);
    check("R6 positive clip", int'(dif_re), 127);
    check_all("satp");
    apply(-128, -128, 127, 127, 127, -128);
    check("R6 negative clip", int'(dif_re), -128);
    check_all("satn");
    apply(127, -128, 127, -128, -128, -128);
    check("R1 extreme sum_re", int'(sum_re), 127);
    check("R2 extreme sum_im", int'(sum_im), -128);
    // R8: zero twiddle
    apply(100, -77, -90, 55, 0, 0);
    check("R8 dif_re", int'(dif_re), 0);
    check("R8 dif_im", int'(dif_im), 0);
    // R7: unity twiddle, B = 0
    for (int k = -128; k < 128; k += 17) begin
      apply(k, -k - 1, 0, 0, 127, 0);
      a = 2 * int'(dif_re) - k;
      check("R7 dif_re near A/2", int'(a >= -2 && a <= 2), 1);
      a = 2 * int'(dif_im) - (-k - 1);
      check("R7 dif_im near A/2", int'(a >= -2 && a <= 2), 1);
    end
    // R9: random vectors back to back, each checked on its own
    for (int n = 0; n < 3000; n++) begin
      apply(int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128,
            int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128,
            int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128);
      check_all("R9 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule